// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Locking Error Flags

This block takes an asynchronous serial line, samples it at sixteen times the bit rate and recovers bytes from it. A byte is framed by one start bit, eight data bits sent least significant bit first, no parity, and one or two stop bits. Each good byte lands in a data register and raises a receive-full flag. Two error flags record overruns and bad stop bits. Once either error flag is set it stays set. Until software clears it, the receiver takes no new frames.

Software uses a small register port with three registers, chosen by a 2-bit select:
- select 0 reads the data register.
- select 1 reads and writes the status register.
- select 2 reads and writes the control register.

Reads are combinational. Their side effects take place at the clock edge where the read strobe is sampled. An error flag clears only through a handshake: software first reads it as 1, then writes 0 to it.

Top module: `sio_rx_top`

## Requirements
- R1: A frame is a low start bit, then 8 data bits least significant bit first, then a stop bit. Each bit lasts 16 oversampling ticks. A frame with a high stop bit places its byte in the data register (select 0) and sets the full flag, which is status bit 0.
- R2: A read strobe on the data register clears the full flag.
- R3: A frame that completes while the full flag is 1 sets the overrun flag (status bit 2). The data register keeps its earlier byte and the new byte is dropped.
- R4: A frame whose first stop bit is sampled low sets the framing flag (status bit 1). Its byte is still written into the data register, and the full flag is left at 0.
- R5: When control bit 1 is set, two stop bits are expected. Only the first one is checked, so a low second stop bit causes no error.
- R6: While the overrun flag or the framing flag is 1, no new frame is received. The data register and the full flag do not change.
- R7: An error flag is cleared by writing 0 to its status bit, and only if that flag was read as 1 since it was last set. A write of 0 without that read has no effect. Writing 1 never sets a flag.
- R8: Control bit 0 enables reception. While it is 0, no frame is taken. Clearing it leaves both error flags unchanged.
- R9: A start is recognised only on a falling edge of the synchronised line. It must then be low again at mid-bit, 8 ticks later. A shorter low pulse is discarded.
- R10: After reset, the status, control and data registers all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| sel_i | input | 2 | Register select: 0 data, 1 status, 2 control |
| rd_i | input | 1 | Read strobe; side effects occur at the clock edge |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |

## Verification
The case hardest to reach is the clear handshake, because it depends on the order of register accesses around the moment a flag is set. To reach it, the bench first provokes an overrun with two back-to-back frames and does not read status. It then writes 0 to the status register, which must have no effect. Only after that does it read the flag and write 0 again. A second frame sent while the flag is still set shows that reception is locked out. A two-stop-bit frame with a low second stop bit exercises the rule that only the first stop bit is checked.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_STOP2
   } rx_state_e;

   localparam logic [1:0] SEL_DATA = 2'd0;
   localparam logic [1:0] SEL_STAT = 2'd1;
   localparam logic [1:0] SEL_CTRL = 2'd2;

   localparam int STAT_FULL = 0;
   localparam int STAT_FER  = 1;
   localparam int STAT_OVR  = 2;
   localparam int CTRL_EN   = 0;
   localparam int CTRL_TWO  = 1;

   localparam int REG_W = 8;
endpackage

// File: rtl/sio_rx_sync.sv
module sio_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q[0] <= 1'b1;
               else        q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q[i] <= 1'b1;
               else        q[i] <= q[i-1];
            end
         end
      end
   endgenerate

   assign dout = q[STAGES-1];
endmodule

// File: rtl/sio_rx_tick.sv
module sio_rx_tick #(
   parameter int DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [TW-1:0] TOP = TW'(DIV - 1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt == TOP) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/sio_rx_frame.sv
module sio_rx_frame
   import sio_rx_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int DATA_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             rx,
   input  logic             en,
   input  logic             lock,
   input  logic             two_stop,
   output logic             done,
   output logic [REG_W-1:0] frm_data,
   output logic             stop_ok
);
   localparam int CW = $clog2(OVS);
   localparam int BW = $clog2(DATA_W);
   localparam logic [CW-1:0] MID   = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST  = CW'(OVS - 1);
   localparam logic [BW-1:0] BLAST = BW'(DATA_W - 1);

   rx_state_e         st;
   logic [CW-1:0]     cnt;
   logic [BW-1:0]     bidx;
   logic [DATA_W-1:0] sh;
   logic              rx_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= RX_IDLE;
         cnt     <= '0;
         bidx    <= '0;
         sh      <= '0;
         rx_prev <= 1'b1;
         done    <= 1'b0;
         stop_ok <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) rx_prev <= rx;
         if (!en) begin
            st <= RX_IDLE;
         end else if (tick) begin
            case (st)
               RX_IDLE: begin
                  if (!lock && rx_prev && !rx) begin
                     st  <= RX_START;
                     cnt <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == MID) begin
                     cnt  <= '0;
                     bidx <= '0;
                     st   <= rx ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt == LAST) begin
                     cnt <= '0;
                     sh  <= {rx, sh[DATA_W-1:1]};
                     if (bidx == BLAST) st <= RX_STOP;
                     else               bidx <= bidx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == LAST) begin
                     cnt     <= '0;
                     done    <= 1'b1;
                     stop_ok <= rx;
                     st      <= two_stop ? RX_STOP2 : RX_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP2: begin
                  if (cnt == LAST) begin
                     cnt <= '0;
                     st  <= RX_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      frm_data = '0;
      frm_data[DATA_W-1:0] = sh;
   end
endmodule

// File: rtl/sio_rx_regs.sv
module sio_rx_regs
   import sio_rx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       sel,
   input  logic             rd,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             done,
   input  logic [REG_W-1:0] frm_data,
   input  logic             stop_ok,
   output logic [REG_W-1:0] rdata,
   output logic             en,
   output logic             two_stop,
   output logic             lock,
   output logic             full,
   output logic             ovr,
   output logic             fer,
   output logic [REG_W-1:0] data_q
);
   logic arm_ovr, arm_fer;
   logic rd_stat, rd_data, wr_stat, wr_ctrl;

   assign rd_stat = rd && (sel == SEL_STAT);
   assign rd_data = rd && (sel == SEL_DATA);
   assign wr_stat = wr && (sel == SEL_STAT);
   assign wr_ctrl = wr && (sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en       <= 1'b0;
         two_stop <= 1'b0;
      end else if (wr_ctrl) begin
         en       <= wdata[CTRL_EN];
         two_stop <= wdata[CTRL_TWO];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full   <= 1'b0;
         data_q <= '0;
      end else begin
         if (rd_data) full <= 1'b0;
         if (done && !full) begin
            data_q <= frm_data;
            if (stop_ok) full <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr     <= 1'b0;
         arm_ovr <= 1'b0;
      end else if (done && full) begin
         ovr     <= 1'b1;
         arm_ovr <= 1'b0;
      end else if (wr_stat && !wdata[STAT_OVR] && arm_ovr) begin
         ovr     <= 1'b0;
         arm_ovr <= 1'b0;
      end else if (rd_stat && ovr) begin
         arm_ovr <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fer     <= 1'b0;
         arm_fer <= 1'b0;
      end else if (done && !full && !stop_ok) begin
         fer     <= 1'b1;
         arm_fer <= 1'b0;
      end else if (wr_stat && !wdata[STAT_FER] && arm_fer) begin
         fer     <= 1'b0;
         arm_fer <= 1'b0;
      end else if (rd_stat && fer) begin
         arm_fer <= 1'b1;
      end
   end

   assign lock = ovr || fer;

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_DATA: rdata = data_q;
         SEL_STAT: begin
            rdata[STAT_FULL] = full;
            rdata[STAT_FER]  = fer;
            rdata[STAT_OVR]  = ovr;
         end
         SEL_CTRL: begin
            rdata[CTRL_EN]  = en;
            rdata[CTRL_TWO] = two_stop;
         end
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/sio_rx_top.sv
module sio_rx_top
   import sio_rx_pkg::*;
#(
   parameter int OVS       = 16,
   parameter int DATA_W    = 8,
   parameter int TICK_DIV  = 1,
   parameter int SYNC_LEN  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_i,
   input  logic [1:0] sel_i,
   input  logic       rd_i,
   input  logic       wr_i,
   input  logic [7:0] wdata_i,
   output logic [7:0] rdata_o
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (DATA_W < 5 || DATA_W > REG_W) begin : g_bad_dw
         $error("DATA_W must lie in 5..8");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (SYNC_LEN < 2) begin : g_bad_sync
         $error("SYNC_LEN must be at least 2");
      end
   endgenerate

   logic             rx_s, tick;
   logic             frm_done, frm_stop_ok;
   logic [REG_W-1:0] frm_data;
   logic             en, two_stop, lock;
   logic             st_full, st_ovr, st_fer;
   logic [REG_W-1:0] data_q;

   sio_rx_sync #(.STAGES(SYNC_LEN)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rx_i), .dout(rx_s)
   );

   sio_rx_tick #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   sio_rx_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s),
      .en(en), .lock(lock), .two_stop(two_stop),
      .done(frm_done), .frm_data(frm_data), .stop_ok(frm_stop_ok)
   );

   sio_rx_regs u_regs (
      .clk(clk), .rst_n(rst_n), .sel(sel_i), .rd(rd_i), .wr(wr_i),
      .wdata(wdata_i), .done(frm_done), .frm_data(frm_data),
      .stop_ok(frm_stop_ok), .rdata(rdata_o), .en(en),
      .two_stop(two_stop), .lock(lock), .full(st_full),
      .ovr(st_ovr), .fer(st_fer), .data_q(data_q)
   );
endmodule

// File: rtl/sio_rx_chk.sv
module sio_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       done,
   input logic       stop_ok,
   input logic       full,
   input logic       ovr,
   input logic       fer,
   input logic [7:0] data_q,
   input logic       rd,
   input logic       wr,
   input logic [1:0] sel,
   input logic [7:0] wdata
);
   AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      done && full |=> ovr && $stable(data_q)); // R3

   AST_OVR_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(done)); // R3

   AST_FER_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      done && !full && !stop_ok |=> fer && !full); // R4

   AST_FULL_CLEAR_READ: assert property (@(posedge clk) disable iff (!rst_n)
      full && rd && sel == 2'd0 |=> !full); // R2

   AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr || fer) |-> !done); // R6

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovr && !(wr && sel == 2'd1 && !wdata[2]) |=> ovr); // R7

   AST_FER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fer && !(wr && sel == 2'd1 && !wdata[1]) |=> fer); // R7
endmodule

bind sio_rx_top sio_rx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .done(frm_done), .stop_ok(frm_stop_ok),
   .full(st_full), .ovr(st_ovr), .fer(st_fer), .data_q(data_q),
   .rd(rd_i), .wr(wr_i), .sel(sel_i), .wdata(wdata_i)
);

// File: tb/tb_sio_rx_top.sv
module tb_sio_rx_top;
   localparam int CLK_PERIOD = 10;
   localparam int BIT_CLKS   = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b1;
   logic [1:0] sel = 2'd0;
   logic       rd = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sio_rx_top dut (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .sel_i(sel), .rd_i(rd),
      .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic reg_rd(input logic [1:0] s, output logic [7:0] v);
      @(negedge clk);
      sel = s;
      rd = 1'b1;
      #1 v = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic reg_wr(input logic [1:0] s, input logic [7:0] v);
      @(negedge clk);
      sel = s;
      wdata = v;
      wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic drive_bit(input logic b);
      rx = b;
      repeat (BIT_CLKS) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] b, input logic s1, input logic s2, input logic two);
      @(negedge clk);
      drive_bit(1'b0);
      for (int i = 0; i < 8; i++) drive_bit(b[i]);
      drive_bit(s1);
      if (two) drive_bit(s2);
      rx = 1'b1;
      repeat (40) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R0 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R10 reset values
      reg_rd(2'd1, v); chk("R10 status", v, 8'h00);
      reg_rd(2'd2, v); chk("R10 control", v, 8'h00);
      reg_rd(2'd0, v); chk("R10 data", v, 8'h00);

      // R8 disabled receiver ignores a frame
      send(8'h33, 1'b1, 1'b1, 1'b0);
      reg_rd(2'd1, v); chk("R8 disabled no full", v, 8'h00);

      reg_wr(2'd2, 8'h01);
      // R1 / R2 sweep of byte values
      for (int k = 0; k < 18; k++) begin
         logic [7:0] b;
         b = (k == 16) ? 8'h00 : (k == 17) ? 8'hFF : 8'((k * 37 + 11) ^ (k << 4));
         send(b, 1'b1, 1'b1, 1'b0);
         reg_rd(2'd1, v); chk("R1 full set", v, 8'h01);
         reg_rd(2'd0, v); chk("R1 data", v, b);
         reg_rd(2'd1, v); chk("R2 full cleared by read", v, 8'h00);
      end

      // R9 short low glitch is discarded
      @(negedge clk);
      rx = 1'b0;
      repeat (4) @(negedge clk);
      rx = 1'b1;
      repeat (300) @(negedge clk);
      reg_rd(2'd1, v); chk("R9 glitch status", v, 8'h00);
      reg_rd(2'd0, v); chk("R9 glitch data", v, 8'hFF);

      // R3 overrun keeps the old byte
      send(8'h11, 1'b1, 1'b1, 1'b0);
      send(8'h22, 1'b1, 1'b1, 1'b0);
      // R7 write 0 without a prior read of the flag
      reg_wr(2'd1, 8'h00);
      reg_rd(2'd1, v); chk("R3 R7 overrun set and kept", v, 8'h05);
      reg_rd(2'd0, v); chk("R3 old byte kept", v, 8'h11);

      // R6 lockout while overrun set
      send(8'h44, 1'b1, 1'b1, 1'b0);
      reg_rd(2'd1, v); chk("R6 locked status", v, 8'h04);
      reg_rd(2'd0, v); chk("R6 locked data", v, 8'h11);

      // R7 write 1 does not clear; write 0 after read clears
      reg_wr(2'd1, 8'hFF);
      reg_rd(2'd1, v); chk("R7 write one keeps flag", v, 8'h04);
      reg_wr(2'd1, 8'h00);
      reg_rd(2'd1, v); chk("R7 handshake clears", v, 8'h00);
      reg_wr(2'd1, 8'hFF);
      reg_rd(2'd1, v); chk("R7 write one never sets", v, 8'h00);

      // R4 framing error
      send(8'h96, 1'b0, 1'b1, 1'b0);
      reg_rd(2'd1, v); chk("R4 framing flag, no full", v, 8'h02);
      reg_rd(2'd0, v); chk("R4 byte stored", v, 8'h96);
      send(8'h0F, 1'b1, 1'b1, 1'b0);
      reg_rd(2'd0, v); chk("R6 framing lockout data", v, 8'h96);
      reg_rd(2'd1, v); chk("R6 framing lockout status", v, 8'h02);

      // R8 disabling keeps flags
      reg_wr(2'd2, 8'h00);
      reg_rd(2'd1, v); chk("R8 disable keeps framing", v, 8'h02);
      reg_wr(2'd1, 8'h00);
      reg_rd(2'd1, v); chk("R7 framing cleared", v, 8'h00);

      // R5 two stop bits
      reg_wr(2'd2, 8'h03);
      reg_rd(2'd2, v); chk("R5 control readback", v, 8'h03);
      send(8'hC3, 1'b1, 1'b0, 1'b1);
      reg_rd(2'd1, v); chk("R5 second stop ignored", v, 8'h01);
      reg_rd(2'd0, v); chk("R5 data", v, 8'hC3);
      send(8'h3C, 1'b0, 1'b1, 1'b1);
      reg_rd(2'd1, v); chk("R5 first stop checked", v, 8'h02);
      reg_rd(2'd0, v); chk("R5 framing data", v, 8'h3C);
      reg_wr(2'd1, 8'h00);
      send(8'h7E, 1'b1, 1'b1, 1'b1);
      reg_rd(2'd1, v); chk("R5 clean two-stop frame", v, 8'h01);
      reg_rd(2'd0, v); chk("R5 clean data", v, 8'h7E);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule